// File: doc/BRIEF.md
# Memory-Window Serial Flash Read Engine

This block lets a processor read an external serial NOR flash as ordinary memory. A read on the bus side of the block becomes a complete flash read. The engine lowers chip select and shifts out an opcode and an address. It then waits a configurable number of dummy clocks, gathers one data word over one, two or four data lines, hands the word back and raises chip select again.

Two registers control the engine. A packed setup word holds the read opcode, the address length, the dummy length and the data line count. A single switch bit decides whether the serial bus belongs to the engine or to a word-at-a-time transfer port that sits beside it. Software programs the setup word once and sets the switch. After that, every read in the window costs no software effort.

Top module: `flash_window_reader`

## Requirements
- R1: After reset, chip select is high, SCLK is low, no IO line is driven, the bus ready output is low and the switch bit is clear, so the engine does not own the serial bus.
- R2: The switch bit comes from `switchWdata` when `switchWe` is high and is visible on `windowOwnsBus`. While it is clear, a window read completes with ready high in the first cycle after the request, returns zero and never lowers chip select.
- R3: A setup word of all zeros disables the engine: a window read then completes in the first cycle and returns zero without touching chip select, even when the switch bit is set.
- R4: The opcode (setup bits 7:0) is sent first and is followed by the address. Both go out on IO0 alone, most significant bit first, and the host drives IO0 only. The setup field at bits 9:8 holds the address byte count minus one (0 gives 1 byte, 3 gives 4 bytes). The low bytes of the zero-extended bus address are sent, most significant byte first.
- R5: After the address, the engine gives 8 × (setup bits 11:10) plus (setup bits 28:24) SCLK cycles with every IO line released. Setup bits 23:16 have no effect on a read.
- R6: Setup bits 13:12 choose the data lines. The value 1 samples IO1:IO0 (IO1 is the more significant bit) and the value 3 samples IO3:IO0 (IO3 most significant). Any other value samples IO1 alone. The data phase therefore lasts 32, 16 or 8 SCLK cycles for one 32-bit word.
- R7: Each byte from the flash is received MSB first. The first byte lands in bits 7:0 of the returned word and the fourth byte in bits 31:24.
- R8: `busReady` stays low from the request until the word is complete and then goes high for exactly one cycle. A request accepted at a clock edge yields ready 2·N cycles later, where N is the total number of SCLK cycles. `busRdData` is zero whenever ready is low.
- R9: Chip select falls once per read. It stays low for the whole sequence and rises in the cycle in which ready is high. SCLK idles low and toggles only while chip select is low. Each SCLK cycle spans two clock cycles and data is sampled on the rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupWe | input | 1 | Load the setup word |
| setupWdata | input | 32 | New setup word |
| switchWe | input | 1 | Load the switch bit |
| switchWdata | input | 1 | New switch bit (1 = engine owns the serial bus) |
| busReq | input | 1 | Window read request, held until ready |
| busAddr | input | ADDR_W | Byte address within the flash window |
| busReady | output | 1 | One-cycle pulse: read word is valid |
| busRdData | output | 8·WORD_BYTES | Returned word, zero when not ready |
| windowOwnsBus | output | 1 | Current switch bit, steers the serial bus |
| flashCsN | output | 1 | Flash chip select, active low |
| flashSclk | output | 1 | Serial clock |
| flashIoOut | output | 4 | Values driven onto IO3..IO0 |
| flashIoOe | output | 4 | Output enables for IO3..IO0 |
| flashIoIn | input | 4 | Values sampled from IO3..IO0 |

## Verification
The bench uses the defaults: a 24-bit window address and a four-byte word. With these values, a 4-byte address setting sends a zero top byte, and a 1-byte setting sends only the lowest address byte, so every address length can be seen at IO0. A flash model beside the bench records the bits on IO0 and counts SCLK edges. It streams a chosen 32-bit byte sequence over one, two or four lines. Each read is checked for its serial header, its edge count, its latency and the byte order of the returned word. The ownership and disable paths are checked for the zero result and the absence of chip select activity.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

  // Bit positions inside the packed setup word
  localparam int OPC_LSB = 0;   // read opcode, 8 bits
  localparam int ADR_LSB = 8;   // address bytes minus one, 2 bits
  localparam int DMB_LSB = 10;  // dummy bytes, 2 bits
  localparam int LN_LSB  = 12;  // data line select, 2 bits
  localparam int XDB_LSB = 24;  // extra dummy bits, 5 bits

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_DUMMY,
    ST_DATA,
    ST_DONE,
    ST_ZERO
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic clearRx;
    logic sampleRx;
  } dpStrobe_t;

endpackage

// File: rtl/fwr_ctrl.sv
module fwr_ctrl
  import fwr_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        setupWe,
  input  logic [31:0] setupWdata,
  input  logic        switchWe,
  input  logic        switchWdata,
  input  logic        busReq,
  output dpStrobe_t   strobe,
  output logic [7:0]  opcode,
  output logic [1:0]  addrField,
  output logic [1:0]  laneSel,
  output logic        csActive,
  output logic        sclkHigh,
  output logic        txDrive,
  output logic        busReady,
  output logic        dataValid,
  output logic        ownsBus
);

  localparam int DATA_BITS = 8 * WORD_BYTES;
  localparam int CNT_W     = $clog2(DATA_BITS + 72);

  logic [31:0]      setupQ;
  logic             ownQ;
  state_e           stateQ;
  logic             halfQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] sendLenQ;
  logic [CNT_W-1:0] dumLenQ;
  logic [CNT_W-1:0] dataLenQ;
  logic [CNT_W-1:0] curLen;
  logic [CNT_W-1:0] sendLenD;
  logic [CNT_W-1:0] dumLenD;
  logic [CNT_W-1:0] dataLenD;
  logic [1:0]       laneQ;
  logic [1:0]       laneD;
  logic             startRd;
  logic             lastBit;
  logic             inXfer;

  // Decode line count: 1 -> two lines, 3 -> four lines, else one line
  always_comb begin
    case (setupQ[LN_LSB +: 2])
      2'd1:    laneD = 2'd1;
      2'd3:    laneD = 2'd2;
      default: laneD = 2'd0;
    endcase
  end

  always_comb begin
    sendLenD = CNT_W'(8 + 8 * (int'(setupQ[ADR_LSB +: 2]) + 1));
    dumLenD  = CNT_W'(8 * int'(setupQ[DMB_LSB +: 2]) + int'(setupQ[XDB_LSB +: 5]));
    dataLenD = CNT_W'(DATA_BITS >> laneD);
  end

  assign startRd = (stateQ == ST_IDLE) && busReq && ownQ && (setupQ != '0);
  assign inXfer  = (stateQ == ST_SEND) || (stateQ == ST_DUMMY) || (stateQ == ST_DATA);

  always_comb begin
    case (stateQ)
      ST_SEND:  curLen = sendLenQ;
      ST_DUMMY: curLen = dumLenQ;
      default:  curLen = dataLenQ;
    endcase
  end

  assign lastBit = inXfer && halfQ && (cntQ == curLen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupQ   <= '0;
      ownQ     <= 1'b0;
      stateQ   <= ST_IDLE;
      halfQ    <= 1'b0;
      cntQ     <= '0;
      sendLenQ <= '0;
      dumLenQ  <= '0;
      dataLenQ <= '0;
      laneQ    <= '0;
    end else begin
      if (setupWe) setupQ <= setupWdata;
      if (switchWe) ownQ <= switchWdata;
      case (stateQ)
        ST_IDLE: begin
          if (startRd) begin
            stateQ   <= ST_SEND;
            halfQ    <= 1'b0;
            cntQ     <= '0;
            sendLenQ <= sendLenD;
            dumLenQ  <= dumLenD;
            dataLenQ <= dataLenD;
            laneQ    <= laneD;
          end else if (busReq) begin
            stateQ <= ST_ZERO;
          end
        end
        ST_SEND, ST_DUMMY, ST_DATA: begin
          halfQ <= ~halfQ;
          if (halfQ) begin
            if (lastBit) begin
              cntQ <= '0;
              if (stateQ == ST_SEND)
                stateQ <= (dumLenQ != '0) ? ST_DUMMY : ST_DATA;
              else if (stateQ == ST_DUMMY)
                stateQ <= ST_DATA;
              else
                stateQ <= ST_DONE;
            end else begin
              cntQ <= cntQ + 1'b1;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadTx   = startRd;
    strobe.clearRx  = startRd;
    strobe.shiftTx  = (stateQ == ST_SEND) && halfQ;
    strobe.sampleRx = (stateQ == ST_DATA) && !halfQ;
  end

  assign opcode    = setupQ[OPC_LSB +: 8];
  assign addrField = setupQ[ADR_LSB +: 2];
  assign laneSel   = laneQ;
  assign csActive  = inXfer;
  assign sclkHigh  = inXfer && halfQ;
  assign txDrive   = (stateQ == ST_SEND);
  assign busReady  = (stateQ == ST_DONE) || (stateQ == ST_ZERO);
  assign dataValid = (stateQ == ST_DONE);
  assign ownsBus   = ownQ;

endmodule

// File: rtl/fwr_datapath.sv
module fwr_datapath
  import fwr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [7:0]                opcode,
  input  logic [1:0]                addrField,
  input  logic [1:0]                laneSel,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic                      txDrive,
  input  logic                      dataValid,
  input  logic [3:0]                ioIn,
  output logic [3:0]                ioOut,
  output logic [3:0]                ioOe,
  output logic [8*WORD_BYTES-1:0]   rdData
);

  localparam int DATA_BITS = 8 * WORD_BYTES;
  localparam int TX_W      = 40;

  logic [31:0]          addrExt;
  logic [31:0]          addrAligned;
  logic [TX_W-1:0]      txQ;
  logic [DATA_BITS-1:0] rxQ;
  logic [DATA_BITS-1:0] swapped;

  always_comb begin
    addrExt = '0;
    addrExt[ADDR_W-1:0] = busAddr;
    // Move the first address byte to be sent into the top position
    addrAligned = addrExt << (8 * (3 - int'(addrField)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ <= '0;
      rxQ <= '0;
    end else begin
      if (strobe.loadTx)       txQ <= {opcode, addrAligned};
      else if (strobe.shiftTx) txQ <= {txQ[TX_W-2:0], 1'b0};

      if (strobe.clearRx) begin
        rxQ <= '0;
      end else if (strobe.sampleRx) begin
        case (laneSel)
          2'd1:    rxQ <= {rxQ[DATA_BITS-3:0], ioIn[1:0]};
          2'd2:    rxQ <= {rxQ[DATA_BITS-5:0], ioIn[3:0]};
          default: rxQ <= {rxQ[DATA_BITS-2:0], ioIn[1]};
        endcase
      end
    end
  end

  // First received byte sits at the top of rxQ; place it at the bottom of the word
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_swap
    assign swapped[8*g +: 8] = rxQ[DATA_BITS-1-8*g -: 8];
  end

  assign rdData = dataValid ? swapped : '0;
  assign ioOut  = {3'b000, txDrive & txQ[TX_W-1]};
  assign ioOe   = {3'b000, txDrive};

endmodule

// File: rtl/flash_window_reader.sv
module flash_window_reader
  import fwr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int WORD_BYTES = 4,
  localparam int DATA_W    = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setupWe,
  input  logic [31:0]       setupWdata,
  input  logic              switchWe,
  input  logic              switchWdata,
  input  logic              busReq,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busReady,
  output logic [DATA_W-1:0] busRdData,
  output logic              windowOwnsBus,
  output logic              flashCsN,
  output logic              flashSclk,
  output logic [3:0]        flashIoOut,
  output logic [3:0]        flashIoOe,
  input  logic [3:0]        flashIoIn
);

  dpStrobe_t  strobe;
  logic [7:0] opcode;
  logic [1:0] addrField;
  logic [1:0] laneSel;
  logic       csActive;
  logic       sclkHigh;
  logic       txDrive;
  logic       dataValid;

  fwr_ctrl #(.WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .setupWe    (setupWe),
    .setupWdata (setupWdata),
    .switchWe   (switchWe),
    .switchWdata(switchWdata),
    .busReq     (busReq),
    .strobe     (strobe),
    .opcode     (opcode),
    .addrField  (addrField),
    .laneSel    (laneSel),
    .csActive   (csActive),
    .sclkHigh   (sclkHigh),
    .txDrive    (txDrive),
    .busReady   (busReady),
    .dataValid  (dataValid),
    .ownsBus    (windowOwnsBus)
  );

  fwr_datapath #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opcode    (opcode),
    .addrField (addrField),
    .laneSel   (laneSel),
    .busAddr   (busAddr),
    .txDrive   (txDrive),
    .dataValid (dataValid),
    .ioIn      (flashIoIn),
    .ioOut     (flashIoOut),
    .ioOe      (flashIoOe),
    .rdData    (busRdData)
  );

  assign flashCsN  = ~csActive;
  assign flashSclk = sclkHigh;

endmodule

// File: rtl/fwr_checker.sv
module fwr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReady,
  input logic [DATA_W-1:0] busRdData,
  input logic              windowOwnsBus,
  input logic              flashCsN,
  input logic              flashSclk,
  input logic [3:0]        flashIoOe
);

  // R9
  sclk_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashSclk |-> !flashCsN);

  // R9
  cs_fall_low_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashCsN) |-> !flashSclk);

  // R9
  cs_rise_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashCsN) |-> busReady);

  // R4
  lane0_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashIoOe[3:1] == 3'b000);

  // R4
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|flashIoOe) |-> !flashCsN);

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  // R8
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |-> (busRdData == '0));

  // R2
  no_start_unowned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flashCsN && !windowOwnsBus) |=> flashCsN);

endmodule

bind flash_window_reader fwr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busReady     (busReady),
  .busRdData    (busRdData),
  .windowOwnsBus(windowOwnsBus),
  .flashCsN     (flashCsN),
  .flashSclk    (flashSclk),
  .flashIoOe    (flashIoOe)
);

// File: tb/sim_flash_window_reader.sv
`timescale 1ns/1ps
module sim_flash_window_reader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupWe = 1'b0;
  logic [31:0] setupWdata = '0;
  logic        switchWe = 1'b0;
  logic        switchWdata = 1'b0;
  logic        busReq = 1'b0;
  logic [23:0] busAddr = '0;
  logic        busReady;
  logic [31:0] busRdData;
  logic        windowOwnsBus;
  logic        flashCsN;
  logic        flashSclk;
  logic [3:0]  flashIoOut;
  logic [3:0]  flashIoOe;
  logic [3:0]  flashIoIn = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_window_reader u0 (
    .clk(clk), .rstN(rstN),
    .setupWe(setupWe), .setupWdata(setupWdata),
    .switchWe(switchWe), .switchWdata(switchWdata),
    .busReq(busReq), .busAddr(busAddr),
    .busReady(busReady), .busRdData(busRdData),
    .windowOwnsBus(windowOwnsBus),
    .flashCsN(flashCsN), .flashSclk(flashSclk),
    .flashIoOut(flashIoOut), .flashIoOe(flashIoOe),
    .flashIoIn(flashIoIn)
  );

  // Flash model settings, chosen by each scenario
  int          preEdges = 8;   // rising edges before data
  int          lanes    = 1;
  int          hdrLen   = 8;   // header bits captured on IO0
  logic [31:0] stream   = '0;  // byte0 in [31:24], each byte MSB first

  int          riseCnt  = 0;
  int          csFalls  = 0;
  logic [63:0] hdrCap   = '0;

  always @(negedge flashCsN) begin
    riseCnt = 0;
    hdrCap  = '0;
    csFalls = csFalls + 1;
  end

  always @(posedge flashSclk) begin
    if (riseCnt < hdrLen) hdrCap = {hdrCap[62:0], flashIoOut[0]};
    riseCnt = riseCnt + 1;
  end

  always @(negedge flashSclk) begin
    int k;
    logic [31:0] sh;
    k = riseCnt - preEdges;
    if (k >= 0 && k < 32 / lanes) begin
      sh = stream << (k * lanes);
      case (lanes)
        2:       flashIoIn <= {2'b00, sh[31:30]};
        4:       flashIoIn <= sh[31:28];
        default: flashIoIn <= {2'b00, sh[31], 1'b0};
      endcase
    end else begin
      flashIoIn <= '0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeSetup(input logic [31:0] v);
    @(negedge clk); setupWe = 1'b1; setupWdata = v;
    @(negedge clk); setupWe = 1'b0;
  endtask

  task automatic writeSwitch(input logic v);
    @(negedge clk); switchWe = 1'b1; switchWdata = v;
    @(negedge clk); switchWe = 1'b0;
  endtask

  task automatic doRead(input logic [23:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    busAddr = a; busReq = 1'b1; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!busReady && lat < 4000);
    d = busRdData;
    busReq = 1'b0;
  endtask

  // One full read with header, edge count, latency and data checks
  task automatic flashRead(input string tag, input logic [31:0] setup, input logic [23:0] a,
                           input int nAddr, input int nDummy, input int nLanes,
                           input logic [31:0] strm);
    logic [31:0] d;
    logic [31:0] expWord;
    logic [63:0] expHdr;
    logic [31:0] aExt;
    int lat, total, cs0;
    writeSetup(setup);
    lanes    = nLanes;
    hdrLen   = 8 + 8 * nAddr;
    preEdges = hdrLen + nDummy;
    stream   = strm;
    total    = preEdges + 32 / nLanes;
    aExt     = {8'h00, a};
    expHdr   = {56'h0, setup[7:0]};
    for (int i = nAddr - 1; i >= 0; i--) expHdr = {expHdr[55:0], aExt[8*i +: 8]};
    expWord  = {strm[7:0], strm[15:8], strm[23:16], strm[31:24]};
    cs0 = csFalls;
    doRead(a, d, lat);
    // R4: opcode then address, MSB first on IO0
    check(hdrCap == expHdr, {tag, " R4 header"}, hdrCap, expHdr);
    // R5 and R6: dummy and data SCLK counts
    check(riseCnt == total, {tag, " R5/R6 sclk edges"}, riseCnt, total);
    // R7: little-endian assembly
    check(d == expWord, {tag, " R7 word"}, d, expWord);
    // R8: ready timing
    check(lat == 2 * total + 1, {tag, " R8 latency"}, lat, 2 * total + 1);
    // R9: a single chip select frame, released at completion
    check(csFalls == cs0 + 1 && flashCsN, {tag, " R9 cs frame"}, csFalls - cs0, 1);
    @(negedge clk);
    check(busRdData == 0 && !busReady, {tag, " R8 data quiet"}, busRdData, 0);
  endtask

  task automatic zeroRead(input string tag, input bit expOwn);
    logic [31:0] d;
    int lat, cs0;
    cs0 = csFalls;
    doRead(24'h00_1234, d, lat);
    check(lat == 1, {tag, " latency"}, lat, 1);
    check(d == 0, {tag, " data"}, d, 0);
    check(csFalls == cs0 && flashCsN, {tag, " no cs"}, csFalls - cs0, 0);
    check(windowOwnsBus == expOwn, {tag, " owner"}, windowOwnsBus, expOwn);
  endtask

  task automatic testReset;
    // R1
    check(flashCsN == 1'b1, "R1 cs idle", flashCsN, 1);
    check(flashSclk == 1'b0, "R1 sclk idle", flashSclk, 0);
    check(flashIoOe == 4'h0, "R1 io released", flashIoOe, 0);
    check(busReady == 1'b0, "R1 ready low", busReady, 0);
    check(windowOwnsBus == 1'b0, "R1 switch clear", windowOwnsBus, 0);
  endtask

  task automatic testUnowned;
    // R2: valid setup but switch clear
    writeSetup(32'h0000_0203);
    zeroRead("R2 unowned", 1'b0);
  endtask

  task automatic testDisabled;
    // R3: switch set, setup zero
    writeSwitch(1'b1);
    writeSetup(32'h0000_0000);
    zeroRead("R3 disabled", 1'b1);
  endtask

  task automatic testReads;
    // R6 single line, 3 address bytes, no dummy
    flashRead("single", 32'h0000_0203, 24'h12_3456, 3, 0, 1, 32'hDEAD_BEEF);
    // R6 dual lines, 3 address bytes, one dummy byte
    flashRead("dual", 32'h0000_166B, 24'h00_ABCD, 3, 8, 2, 32'h0123_4567);
    // R5 quad, 4 address bytes, 6 extra dummy bits, write opcode field set (ignored)
    flashRead("quad", 32'h0612_336C, 24'hFE_DCBA, 4, 6, 4, 32'hA1B2_C3D4);
    // R4 one address byte, R5 two dummy bytes
    flashRead("short", 32'h0000_080B, 24'h00_007E, 1, 16, 1, 32'h8001_FF10);
    // R6 line field value 2 falls back to single
    flashRead("lane2", 32'h0000_2203, 24'h55_AA33, 3, 0, 1, 32'h3C5A_96F0);
  endtask

  task automatic testHandBack;
    // R2: clearing the switch returns the bus
    writeSetup(32'h0000_0203);
    writeSwitch(1'b0);
    zeroRead("R2 handback", 1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnowned();
    testDisabled();
    testReads();
    testHandBack();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule